// File: doc/BRIEF.md
# Pipeline Stall Hold Controller

This block decides, cycle by cycle, which stages of a seven-stage instruction pipeline may move forward. The stages are, in order, a program-wait stage (PW) that waits for a fetch packet to reach the core, a dispatch stage (DP) that hands out execute packets, and five execute stages E1 to E5. The controller keeps a valid bit for every stage and a load marker for every execute stage. From these it produces one advance enable per stage and a two-bit code that names the current stall cause.

A stall can come from three sources, and each one halts a different part of the pipeline. A fetch packet that carries several execute packets keeps PW and DP in place while its packets leave one per cycle, and the execute stages keep moving. A fetch packet that has not arrived when DP needs one freezes the whole pipeline. A load that reaches E3 before data memory has answered also freezes the whole pipeline. A store never stalls, whatever the data-memory handshake shows.

Top module: `ep_hold_ctrl`

## Requirements
- R1: While reset is active, every bit of `stage_valid` is 0 and `stall_cause` is 00.
- R2: `stage_valid` bit 0 is PW, bit 1 is DP and bits 2 to 6 are E1 to E5. In every cycle without a freeze, each execute stage's content moves one stage on, and E1 receives an execute packet only if DP was valid.
- R3: A fetch packet whose count is N (N greater than 1) stays in DP for N cycles and sends one execute packet to E1 in each of them. In the first N-1 of these cycles `stall_cause` is 01 (dispatch).
- R4: After the first cycle out of reset, if DP is empty or is sending its last execute packet and `fp_ready` is low, `stall_cause` is 10 (fetch), all advance enables are 0 and no stage changes state.
- R5: When E3 holds a load and `ld_ready` is low, `stall_cause` is 11 (load data), all advance enables are 0 and no stage changes state.
- R6: `ld_ready` is sampled in the same cycle. A load that finds it high in E3 moves on with zero stall cycles, and an ongoing load stall ends in the cycle in which `ld_ready` is high.
- R7: `dp_is_store` has no effect. Execute packets marked as stores never produce code 11, even while `ld_ready` is low.
- R8: When several causes are present, load data (11) takes priority over fetch (10), and fetch takes priority over dispatch (01).
- R9: `stage_adv` uses the bit order of `stage_valid`. During a dispatch stall bits 0 and 1 are 0 and bits 2 to 6 are 1. With no stall, all bits are 1.
- R10: A fetch packet count of 0 is handled the same way as a count of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fp_ready | input | 1 | Fetch packet available at the core boundary |
| fp_ep_cnt | input | EP_W | Number of execute packets in the arriving fetch packet |
| dp_is_load | input | 1 | Execute packet now in DP contains a load |
| dp_is_store | input | 1 | Execute packet now in DP contains a store |
| ld_ready | input | 1 | Data memory has returned read data |
| stage_valid | output | 7 | Occupancy: bit 0 PW, bit 1 DP, bits 2-6 E1-E5 |
| stage_adv | output | 7 | Advance enable per stage, same bit order |
| stall_cause | output | 2 | 00 none, 01 dispatch, 10 fetch, 11 load data |

## Verification
The bench runs phases of one-packet fetches, multi-packet fetches, zero counts, a fetch handshake held low, loads with `ld_ready` low, pulsed and held high, and stores with `ld_ready` held low. A long random phase then mixes all inputs. The held-low fetch phase shows that a whole-pipeline freeze differs from a dispatch hold, which lets E1 to E5 keep draining. The load and store phases show that only loads are sensitive to data readiness, and the held-high phase shows that a ready load costs no cycles. The random phase makes several causes occur together, which exercises the priority order of the cause code.

// File: rtl/ep_hold_ctrl.sv
module ep_hold_ctrl #(
  parameter int EP_W = 3,
  localparam int NEX = 5,
  localparam int NSTG = NEX + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fp_ready,
  input  logic [EP_W-1:0] fp_ep_cnt,
  input  logic            dp_is_load,
  input  logic            dp_is_store,
  input  logic            ld_ready,
  output logic [NSTG-1:0] stage_valid,
  output logic [NSTG-1:0] stage_adv,
  output logic [1:0]      stall_cause
);

  logic            pw_v, dp_v;
  logic [EP_W-1:0] dp_left;
  logic [NEX-1:0]  ex_v, ex_ld;

  wire last_ep = dp_left == EP_W'(1);
  wire need_fp = pw_v && (!dp_v || last_ep);
  wire f_stall = need_fp && !fp_ready;
  wire l_stall = ex_v[2] && ex_ld[2] && !ld_ready;
  wire d_stall = dp_v && !last_ep;
  wire hold    = f_stall || l_stall;
  wire [EP_W-1:0] new_cnt = (fp_ep_cnt == '0) ? EP_W'(1) : fp_ep_cnt;
  wire unused_store = dp_is_store;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pw_v    <= 1'b0;
      dp_v    <= 1'b0;
      dp_left <= '0;
      ex_v    <= '0;
      ex_ld   <= '0;
    end else begin
      pw_v <= 1'b1;
      if (!hold) begin
        ex_v  <= {ex_v[NEX-2:0], dp_v};
        ex_ld <= {ex_ld[NEX-2:0], dp_v && dp_is_load};
        if (d_stall) begin
          dp_left <= dp_left - EP_W'(1);
        end else if (need_fp) begin
          dp_v    <= 1'b1;
          dp_left <= new_cnt;
        end
      end
    end
  end

  assign stage_valid = {ex_v, dp_v, pw_v};
  assign stage_adv   = {{NEX{!hold}}, {2{!hold && !d_stall}}};
  assign stall_cause = l_stall ? 2'b11 : f_stall ? 2'b10 : d_stall ? 2'b01 : 2'b00;

  assert_load_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_v[2] && ex_ld[2] && !ld_ready) |=> ($stable(ex_v) && $stable(ex_ld) && $stable(dp_left)));
  assert_fetch_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_cause == 2'b10) |=> $stable(stage_valid));
  assert_disp_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_cause == 2'b01) |=> (ex_v[0] && dp_v && dp_left == $past(dp_left) - EP_W'(1)));
  assert_ready_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_cause == 2'b11) |-> !ld_ready);
  assert_count_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dp_v |-> (dp_left != '0));
  assert_no_adv_on_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall_cause[1] |-> (stage_adv == '0));

endmodule

// File: tb/ep_hold_ctrl_test.sv
`timescale 1ns/1ps
module ep_hold_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fp_ready = 1'b0, dp_is_load = 1'b0, dp_is_store = 1'b0, ld_ready = 1'b0;
  logic [2:0] fp_ep_cnt = 3'd1;
  logic [6:0] stage_valid, stage_adv;
  logic [1:0] stall_cause;

  int tests = 0, fails = 0;
  bit done = 0;

  ep_hold_ctrl #(.EP_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .fp_ready(fp_ready), .fp_ep_cnt(fp_ep_cnt),
    .dp_is_load(dp_is_load), .dp_is_store(dp_is_store), .ld_ready(ld_ready),
    .stage_valid(stage_valid), .stage_adv(stage_adv), .stall_cause(stall_cause));

  always #2.5 clk = ~clk;

  // behavioural occupancy model
  bit m_pw, m_dp;
  int m_left;
  bit m_ev[5], m_el[5];
  int e_cause;
  bit e_freeze, e_dst, e_need;
  logic [6:0] e_valid, e_adv;

  task automatic model_reset();
    m_pw = 0; m_dp = 0; m_left = 0;
    foreach (m_ev[i]) begin m_ev[i] = 0; m_el[i] = 0; end
  endtask

  task automatic model_eval();
    bit fst, lst;
    e_need = m_pw && (!m_dp || m_left == 1);
    fst = e_need && !fp_ready;
    lst = m_ev[2] && m_el[2] && !ld_ready;
    e_dst = m_dp && m_left > 1;
    e_freeze = fst || lst;
    e_cause = lst ? 3 : fst ? 2 : e_dst ? 1 : 0;
    e_valid[0] = m_pw; e_valid[1] = m_dp;
    for (int i = 0; i < 5; i++) e_valid[i+2] = m_ev[i];
    e_adv[1:0] = {2{!e_freeze && !e_dst}};
    e_adv[6:2] = {5{!e_freeze}};
  endtask

  task automatic model_step();
    bit dl;
    dl = m_dp && dp_is_load;
    if (!e_freeze) begin
      for (int i = 4; i > 0; i--) begin m_ev[i] = m_ev[i-1]; m_el[i] = m_el[i-1]; end
      m_ev[0] = m_dp; m_el[0] = dl;
      if (e_dst) m_left = m_left - 1;
      else if (e_need) begin
        m_dp = 1;
        m_left = (fp_ep_cnt == 0) ? 1 : int'(fp_ep_cnt);
      end
    end
    m_pw = 1;
  endtask

  task automatic check(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // inputs set at negedge before call; compares then crosses one posedge
  task automatic step(string tag);
    #1;
    model_eval();
    check(tag, "stage_valid", int'(stage_valid), int'(e_valid));
    check(tag, "stage_adv", int'(stage_adv), int'(e_adv));
    check(tag, "stall_cause", int'(stall_cause), e_cause);
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    #1;
    check("R1", "reset stage_valid", int'(stage_valid), 0);
    check("R1", "reset stall_cause", int'(stall_cause), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R4: fetch handshake held low, whole pipeline frozen
    fp_ready = 0;
    for (int i = 0; i < 5; i++) step("R4");
    // R2: one execute packet per fetch packet
    fp_ready = 1; fp_ep_cnt = 3'd1;
    for (int i = 0; i < 10; i++) step("R2");
    // R3 / R9: multi-packet fetch, execute stages drain during dispatch hold
    fp_ep_cnt = 3'd4;
    for (int i = 0; i < 14; i++) step("R3");
    fp_ep_cnt = 3'd3;
    for (int i = 0; i < 12; i++) begin fp_ready = (i % 5) != 2; step("R9"); end
    // R10: count zero acts as one
    fp_ready = 1; fp_ep_cnt = 3'd0;
    for (int i = 0; i < 8; i++) step("R10");
    // R5: loads with data ready pulsed
    fp_ep_cnt = 3'd1; dp_is_load = 1;
    for (int i = 0; i < 20; i++) begin ld_ready = (i % 4) == 3; step("R5"); end
    // R6: loads meeting ready already high
    ld_ready = 1;
    for (int i = 0; i < 12; i++) step("R6");
    // R7: stores while data memory is not ready
    dp_is_load = 0; dp_is_store = 1; ld_ready = 0;
    for (int i = 0; i < 12; i++) step("R7");
    // R8: mixed random traffic, overlapping causes
    for (int i = 0; i < 400; i++) begin
      fp_ready    = ($urandom % 4) != 0;
      fp_ep_cnt   = 3'($urandom % 8);
      dp_is_load  = $urandom % 2;
      dp_is_store = $urandom % 2;
      ld_ready    = ($urandom % 3) != 0;
      step("R8");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule